// File: doc/BRIEF.md
# Smartcard Character Retry Controller

This block sits beside the UART core of a half-duplex smartcard link and decides, one character at a time, how to recover from errors. On the receive side it looks at each finished character. A character with bad parity is refused with a NACK request to the shifter, and the block counts the refusal. A character with good parity is handed on as ready data. Once the retry budget is used up, the block stops refusing: it delivers the character and raises the parity error flag.

On the transmit side it watches for the card's NACK. While budget remains it asks the transmitter to send the same character again. When a NACK arrives after the budget is spent, it raises the framing error flag instead. Both directions share one 3-bit budget. The budget can be set to any value while the peripheral is off. While the peripheral is on, the only write accepted is zero, and that write cancels any retry sequence at once.

All strobe outputs are registered and come one cycle after the input event that causes them. The error flags follow one cycle after the internal give-up strobe and stay set until they are cleared.

Top module: `sc_retry_ctrl`

## Requirements
- R1: After reset every output is 0 and the retry budget is 0.
- R2: With `periph_en`=0, a write through `cfg_wr` loads any value from 0 to 7 into the budget. With `periph_en`=1, a write of a nonzero value is ignored and the budget keeps its old value.
- R3: A write of 0 is always accepted and clears both retry counters in the same cycle. A NACK arriving in that cycle, or any later one, raises the framing error and produces no retransmit.
- R4: In smartcard mode, a `tx_nack` strobe seen while the transmit count is below the budget gives a one-cycle `retx_req` in the next cycle, and the count goes up by one.
- R5: A `tx_nack` seen when the transmit count equals the budget gives no `retx_req` and sets `frame_err` two cycles later. With a budget of 0, the first NACK already does this.
- R6: A `tx_accept` strobe, which marks a new character accepted for transmit, resets the transmit count to 0.
- R7: A finished character without a parity error gives a `data_ready` strobe in the next cycle, never a NACK, and resets the receive count to 0.
- R8: A finished character with a parity error, in smartcard mode with `nack_en`=1 and the receive count below the budget, gives a one-cycle `nack_drive` and no `data_ready`. The count goes up by one.
- R9: A parity-error character arriving with the receive count equal to the budget gives `data_ready` and then `parity_err`, with no NACK. The count returns to 0.
- R10: With `nack_en`=0, every parity-error character is delivered at once with `data_ready` and `parity_err` and no NACK.
- R11: With `sc_en`=0, `tx_nack` has no effect, and a parity-error character is delivered with `data_ready` and `parity_err` and no NACK.
- R12: `frame_err` and `parity_err` stay set until their clear strobe. If a clear strobe and a new set arrive in the same cycle, the set wins.
- R13: `nack_drive` and `data_ready` are never high in the same cycle, and `retx_req` never comes from an event that also gives up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enabled; limits budget writes |
| sc_en | input | 1 | Smartcard recovery mode on |
| nack_en | input | 1 | Allow NACK on receive parity error |
| cfg_wr | input | 1 | Budget write strobe |
| cfg_wdata | input | 3 | Budget write value |
| tx_accept | input | 1 | New character taken for transmit |
| tx_nack | input | 1 | NACK detected from the card after a transmitted character |
| rx_done | input | 1 | Received character finished (end of stop bit) |
| rx_perr | input | 1 | Parity error on the finished character, qualified by rx_done |
| clr_frame | input | 1 | Clear framing error flag |
| clr_parity | input | 1 | Clear parity error flag |
| retx_req | output | 1 | Retransmit the same character (strobe) |
| nack_drive | output | 1 | Drive a NACK on the line (strobe) |
| data_ready | output | 1 | Received character delivered (strobe) |
| frame_err | output | 1 | Transmit retries exhausted (sticky) |
| parity_err | output | 1 | Receive retries exhausted or error delivered (sticky) |

## Verification
The checker watches, on every cycle, that each strobe is caused by an input event of the right kind one cycle earlier. It also checks that NACK and data delivery never occur together, that a good-parity character always ends in delivery, that the flags hold until cleared, and that the transmit path stays quiet while smartcard mode is off. Counting behaviour cannot be seen from single cycles, and only the bench scenarios show it. This covers the exact number of refusals before a give-up for each budget, the count reset on a new transmit character, writes rejected while enabled, and an abort that arrives in the middle of a sequence.

// File: rtl/sc_retry_pkg.sv
package sc_retry_pkg;

    typedef enum logic [1:0] {
        RX_NONE   = 2'd0,
        RX_ACCEPT = 2'd1,
        RX_REFUSE = 2'd2,
        RX_GIVEUP = 2'd3
    } rx_act_e;

    typedef enum logic [1:0] {
        TX_NONE  = 2'd0,
        TX_RETRY = 2'd1,
        TX_FAIL  = 2'd2
    } tx_act_e;

endpackage

// File: rtl/sc_budget_reg.sv
module sc_budget_reg #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_en,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] budget_o,
    output logic             abort_o
);

    typedef struct packed {
        logic [CNT_W-1:0] budget;
    } st_t;

    st_t st_d, st_q;
    logic wr_ok;

    always_comb begin
        st_d  = st_q;
        // Running peripheral: only a zero write may pass
        wr_ok = cfg_wr && (!periph_en || (cfg_wdata == '0));
        if (wr_ok) begin
            st_d.budget = cfg_wdata;
        end
        budget_o = st_d.budget;
        abort_o  = wr_ok && (cfg_wdata == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sc_tx_retry.sv
module sc_tx_retry
    import sc_retry_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sc_en,
    input  logic [CNT_W-1:0] budget,
    input  logic             abort,
    input  logic             tx_accept,
    input  logic             tx_nack,
    output logic             retx_o,
    output logic             fail_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             retx;
        logic             fail;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] cnt_now;
    tx_act_e          act;

    always_comb begin
        cnt_now = abort ? '0 : st_q.cnt;
        act     = TX_NONE;
        if (sc_en && !tx_accept && tx_nack) begin
            act = (cnt_now < budget) ? TX_RETRY : TX_FAIL;
        end

        st_d      = st_q;
        st_d.retx = 1'b0;
        st_d.fail = 1'b0;
        case (act)
            TX_RETRY: begin
                st_d.retx = 1'b1;
                st_d.cnt  = CNT_W'(cnt_now + 1'b1);
            end
            TX_FAIL: begin
                st_d.fail = 1'b1;
                st_d.cnt  = '0;
            end
            default: begin
                st_d.cnt = (!sc_en || tx_accept) ? '0 : cnt_now;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign retx_o = st_q.retx;
    assign fail_o = st_q.fail;

endmodule

// File: rtl/sc_rx_retry.sv
module sc_rx_retry
    import sc_retry_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sc_en,
    input  logic             nack_en,
    input  logic [CNT_W-1:0] budget,
    input  logic             abort,
    input  logic             rx_done,
    input  logic             rx_perr,
    output logic             nack_o,
    output logic             ready_o,
    output logic             perr_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             nack;
        logic             ready;
        logic             perr;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] cnt_now;
    rx_act_e          act;

    always_comb begin
        cnt_now = abort ? '0 : st_q.cnt;
        act     = RX_NONE;
        if (rx_done) begin
            if (!rx_perr) begin
                act = RX_ACCEPT;
            end else if (sc_en && nack_en && (cnt_now < budget)) begin
                act = RX_REFUSE;
            end else begin
                act = RX_GIVEUP;
            end
        end

        st_d       = st_q;
        st_d.nack  = 1'b0;
        st_d.ready = 1'b0;
        st_d.perr  = 1'b0;
        st_d.cnt   = sc_en ? cnt_now : '0;
        case (act)
            RX_ACCEPT: begin
                st_d.ready = 1'b1;
                st_d.cnt   = '0;
            end
            RX_REFUSE: begin
                st_d.nack = 1'b1;
                st_d.cnt  = CNT_W'(cnt_now + 1'b1);
            end
            RX_GIVEUP: begin
                st_d.ready = 1'b1;
                st_d.perr  = 1'b1;
                st_d.cnt   = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nack_o  = st_q.nack;
    assign ready_o = st_q.ready;
    assign perr_o  = st_q.perr;

endmodule

// File: rtl/sc_retry_ctrl.sv
module sc_retry_ctrl #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_en,
    input  logic             sc_en,
    input  logic             nack_en,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             tx_accept,
    input  logic             tx_nack,
    input  logic             rx_done,
    input  logic             rx_perr,
    input  logic             clr_frame,
    input  logic             clr_parity,
    output logic             retx_req,
    output logic             nack_drive,
    output logic             data_ready,
    output logic             frame_err,
    output logic             parity_err
);

    typedef struct packed {
        logic frame;
        logic parity;
    } flag_t;

    logic [CNT_W-1:0] budget;
    logic             abort;
    logic             tx_fail;
    logic             rx_perr_evt;
    flag_t            fl_d, fl_q;

    sc_budget_reg #(.CNT_W(CNT_W)) budget_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_en (periph_en),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .budget_o  (budget),
        .abort_o   (abort)
    );

    sc_tx_retry #(.CNT_W(CNT_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_en     (sc_en),
        .budget    (budget),
        .abort     (abort),
        .tx_accept (tx_accept),
        .tx_nack   (tx_nack),
        .retx_o    (retx_req),
        .fail_o    (tx_fail)
    );

    sc_rx_retry #(.CNT_W(CNT_W)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sc_en   (sc_en),
        .nack_en (nack_en),
        .budget  (budget),
        .abort   (abort),
        .rx_done (rx_done),
        .rx_perr (rx_perr),
        .nack_o  (nack_drive),
        .ready_o (data_ready),
        .perr_o  (rx_perr_evt)
    );

    // Sticky flags: a new event outranks a clear in the same cycle
    always_comb begin
        fl_d = fl_q;
        if (clr_frame)   fl_d.frame  = 1'b0;
        if (tx_fail)     fl_d.frame  = 1'b1;
        if (clr_parity)  fl_d.parity = 1'b0;
        if (rx_perr_evt) fl_d.parity = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign frame_err  = fl_q.frame;
    assign parity_err = fl_q.parity;

endmodule

// File: rtl/sc_retry_checker.sv
module sc_retry_checker (
    input logic clk,
    input logic rst_n,
    input logic sc_en,
    input logic nack_en,
    input logic tx_nack,
    input logic rx_done,
    input logic rx_perr,
    input logic clr_frame,
    input logic clr_parity,
    input logic retx_req,
    input logic nack_drive,
    input logic data_ready,
    input logic frame_err,
    input logic parity_err
);

    AST_RETX_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        retx_req |-> ($past(tx_nack) && $past(sc_en))); // R4

    AST_NACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        nack_drive |-> ($past(rx_done) && $past(rx_perr) && $past(nack_en) && $past(sc_en))); // R8

    AST_READY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> $past(rx_done)); // R7

    AST_GOOD_CHAR_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_perr) |=> (data_ready && !nack_drive)); // R7

    AST_NACK_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nack_drive && data_ready)); // R13

    AST_SC_OFF_NO_RETX: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_en |=> !retx_req); // R11

    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !clr_frame) |=> frame_err); // R12

    AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !clr_parity) |=> parity_err); // R12

endmodule

bind sc_retry_ctrl sc_retry_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_en      (sc_en),
    .nack_en    (nack_en),
    .tx_nack    (tx_nack),
    .rx_done    (rx_done),
    .rx_perr    (rx_perr),
    .clr_frame  (clr_frame),
    .clr_parity (clr_parity),
    .retx_req   (retx_req),
    .nack_drive (nack_drive),
    .data_ready (data_ready),
    .frame_err  (frame_err),
    .parity_err (parity_err)
);

// File: tb/sc_retry_ctrl_tb_top.sv
module sc_retry_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_en = 1'b0, sc_en = 1'b0, nack_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic       tx_accept = 1'b0, tx_nack = 1'b0;
    logic       rx_done = 1'b0, rx_perr = 1'b0;
    logic       clr_frame = 1'b0, clr_parity = 1'b0;
    logic       retx_req, nack_drive, data_ready, frame_err, parity_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sc_retry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .sc_en(sc_en),
        .nack_en(nack_en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .tx_accept(tx_accept), .tx_nack(tx_nack), .rx_done(rx_done),
        .rx_perr(rx_perr), .clr_frame(clr_frame), .clr_parity(clr_parity),
        .retx_req(retx_req), .nack_drive(nack_drive), .data_ready(data_ready),
        .frame_err(frame_err), .parity_err(parity_err)
    );

    // {sc_en, nack_en, budget[2:0], bad_chars[3:0]}
    localparam logic [8:0] RX_VEC [0:7] = '{
        {1'b1, 1'b1, 3'd3, 4'd2},
        {1'b1, 1'b1, 3'd2, 4'd4},
        {1'b1, 1'b1, 3'd0, 4'd2},
        {1'b1, 1'b0, 3'd5, 4'd2},
        {1'b0, 1'b1, 3'd7, 4'd2},
        {1'b1, 1'b1, 3'd7, 4'd7},
        {1'b1, 1'b1, 3'd1, 4'd3},
        {1'b1, 1'b1, 3'd7, 4'd8}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_budget(input logic [2:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic set_budget_off(input logic [2:0] v);
        periph_en = 1'b0;
        wr_budget(v);
        periph_en = 1'b1;
    endtask

    // One received character; checks strobes, then the flag, then clears it
    task automatic rx_char(input logic p, input logic exp_nack, input logic exp_rdy,
                           input logic exp_perr, input string req);
        @(negedge clk); rx_done = 1'b1; rx_perr = p;
        @(negedge clk); rx_done = 1'b0; rx_perr = 1'b0;
        chk({req, " nack_drive"}, nack_drive, exp_nack);
        chk({req, " data_ready"}, data_ready, exp_rdy);
        @(negedge clk);
        chk({req, " parity_err"}, parity_err, exp_perr);
        clr_parity = 1'b1;
        @(negedge clk); clr_parity = 1'b0;
    endtask

    task automatic tx_nack_ev(input logic exp_retx, input logic exp_ferr, input string req);
        @(negedge clk); tx_nack = 1'b1;
        @(negedge clk); tx_nack = 1'b0;
        chk({req, " retx_req"}, retx_req, exp_retx);
        @(negedge clk);
        chk({req, " frame_err"}, frame_err, exp_ferr);
        clr_frame = 1'b1;
        @(negedge clk); clr_frame = 1'b0;
    endtask

    task automatic tx_new_char();
        @(negedge clk); tx_accept = 1'b1;
        @(negedge clk); tx_accept = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 retx_req", retx_req, 1'b0);
        chk("R1 nack_drive", nack_drive, 1'b0);
        chk("R1 data_ready", data_ready, 1'b0);
        chk("R1 frame_err", frame_err, 1'b0);
        chk("R1 parity_err", parity_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: budget 0 after reset -> first NACK fails at once
        sc_en = 1'b1; nack_en = 1'b1; periph_en = 1'b1;
        tx_nack_ev(1'b0, 1'b1, "R1/R5 budget0");

        // Table of receive scenarios (R7 R8 R9 R10 R11)
        for (int v = 0; v < 8; v++) begin
            logic s, n;
            int b, nbad, c;
            s = RX_VEC[v][8]; n = RX_VEC[v][7];
            b = int'(RX_VEC[v][6:4]); nbad = int'(RX_VEC[v][3:0]);
            sc_en = s; nack_en = n;
            set_budget_off(RX_VEC[v][6:4]);
            c = 0;
            for (int k = 0; k < nbad; k++) begin
                if (s && n && c < b) begin
                    rx_char(1'b1, 1'b1, 1'b0, 1'b0, "R8 refuse");
                    c++;
                end else begin
                    rx_char(1'b1, 1'b0, 1'b1, 1'b1, "R9/R10/R11 giveup");
                    c = 0;
                end
            end
            rx_char(1'b0, 1'b0, 1'b1, 1'b0, "R7 good");
        end

        // R7: good char resets receive count (budget 2: bad, good, bad, bad, bad->giveup)
        sc_en = 1'b1; nack_en = 1'b1;
        set_budget_off(3'd2);
        rx_char(1'b1, 1'b1, 1'b0, 1'b0, "R7 pre");
        rx_char(1'b0, 1'b0, 1'b1, 1'b0, "R7 good mid");
        rx_char(1'b1, 1'b1, 1'b0, 1'b0, "R7 after reset 1");
        rx_char(1'b1, 1'b1, 1'b0, 1'b0, "R7 after reset 2");
        rx_char(1'b1, 1'b0, 1'b1, 1'b1, "R9 exhausted");

        // R4 R5: budget 2 transmit
        tx_new_char();
        tx_nack_ev(1'b1, 1'b0, "R4 retry1");
        tx_nack_ev(1'b1, 1'b0, "R4 retry2");
        tx_nack_ev(1'b0, 1'b1, "R5 exhausted");

        // R6: new character resets count
        tx_new_char();
        tx_nack_ev(1'b1, 1'b0, "R6 first");
        tx_new_char();
        tx_nack_ev(1'b1, 1'b0, "R6 after accept 1");
        tx_nack_ev(1'b1, 1'b0, "R6 after accept 2");
        tx_nack_ev(1'b0, 1'b1, "R6 exhausted");

        // R2: nonzero write while enabled is ignored (budget stays 2)
        tx_new_char();
        wr_budget(3'd5);
        tx_nack_ev(1'b1, 1'b0, "R2 retry1");
        tx_nack_ev(1'b1, 1'b0, "R2 retry2");
        tx_nack_ev(1'b0, 1'b1, "R2 ignored write");

        // R3: zero write while enabled aborts a sequence in progress
        set_budget_off(3'd3);
        tx_new_char();
        tx_nack_ev(1'b1, 1'b0, "R3 before abort");
        wr_budget(3'd0);
        tx_nack_ev(1'b0, 1'b1, "R3 after abort");
        // R3: abort on the same cycle as a NACK
        set_budget_off(3'd3);
        tx_new_char();
        @(negedge clk); tx_nack = 1'b1; cfg_wr = 1'b1; cfg_wdata = 3'd0;
        @(negedge clk); tx_nack = 1'b0; cfg_wr = 1'b0;
        chk("R3 same-cycle retx_req", retx_req, 1'b0);
        @(negedge clk);
        chk("R3 same-cycle frame_err", frame_err, 1'b1);
        clr_frame = 1'b1;
        @(negedge clk); clr_frame = 1'b0;

        // R11: smartcard off, NACK ignored
        set_budget_off(3'd4);
        sc_en = 1'b0;
        tx_nack_ev(1'b0, 1'b0, "R11 sc off");
        sc_en = 1'b1;

        // R12: sticky flag, and set wins over clear
        set_budget_off(3'd0);
        @(negedge clk); tx_nack = 1'b1;
        @(negedge clk); tx_nack = 1'b0; clr_frame = 1'b1;
        @(negedge clk); clr_frame = 1'b0;
        chk("R12 set beats clear", frame_err, 1'b1);
        repeat (3) @(negedge clk);
        chk("R12 held", frame_err, 1'b1);
        clr_frame = 1'b1;
        @(negedge clk); clr_frame = 1'b0;
        chk("R12 cleared", frame_err, 1'b0);

        // R13: refuse and deliver never together
        set_budget_off(3'd1);
        rx_char(1'b1, 1'b1, 1'b0, 1'b0, "R13 refuse only");
        rx_char(1'b1, 1'b0, 1'b1, 1'b1, "R13 deliver only");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule